// File: doc/BRIEF.md
# Ordered Controller Reset Sequencer

This block brings a serial-link controller out of cold reset without software in the loop. After a start pulse it lifts seven controller reset outputs one at a time, turns on the application and reference clock enables between them, and twice waits for a power-management unit to withdraw a reset request. It then fires a one-cycle application reset pulse, releases the downstream peripheral (active-low at the pin) and reports done after a settling interval. Link training is enabled only once done is reported.

Both waits sample their request once per microsecond tick and give up after a set number of microseconds. A timeout unwinds every step already taken, newest first and one per clock, and then raises an error code that names the failed wait. A stop pulse, accepted in any state except the stop and hold states, clears training, asserts all seven core resets together, gates both clocks and asserts the peripheral reset, one step per cycle. It then holds off new starts for a long quiet interval. All delays are counted in microseconds from a tick divided down from the clock using the `CLK_MHZ` parameter.

States and transitions: IDLE goes to REL_PWR on start. The chain REL_PWR, REL_HOT, WAIT_PHY, REL_PHY, EN_APPCLK, EN_REFCLK, WAIT_CORE, REL_PIPE, REL_CORE, PULSE_APP, REL_STICKY, REL_NSTICKY, REL_PERIPH, SETTLE, DONE advances one state per cycle. There are three exceptions. WAIT_PHY and WAIT_CORE advance on a tick with their request low, or go to UNWIND when the poll timer expires. SETTLE goes to DONE when the settle timer expires. DONE stays there. UNWIND steps back one action per cycle and goes to FAILED at the last one. FAILED goes to IDLE. A stop takes any other state to STOP_TRAIN, which then runs STOP_CORE, STOP_CLK, STOP_PERIPH and HOLD. HOLD goes to IDLE when the hold timer expires.

Top module: `ctrl_reset_sequencer`

## Requirements
- R1: While reset is applied and afterwards until a start, all seven core resets read 1, both clock enables, the application pulse and the training enable read 0, the peripheral reset pin reads 0, and done and error read 0.
- R2: After an accepted start the outputs change in this order, each strictly later than the previous one: core reset bit 0 (power), bit 1 (hot), bit 2 (PHY), application clock enable, reference clock enable, bit 3 (pipe), bit 4 (core), the application pulse, bit 5 (sticky), bit 6 (non-sticky), and the peripheral reset pin going high.
- R3: Core reset bit 2 is not released while the PHY reset request is high. It is released within CLK_MHZ+3 cycles after the request drops.
- R4: Core reset bit 3 is not released while the core reset request is high. It is released within CLK_MHZ+3 cycles after the request drops.
- R5: A request that stays high for POLL_US microseconds of a wait ends the sequence with error code 1 for the PHY wait or 2 for the core wait. Code 3 never appears.
- R6: On a timeout every step already taken is undone in reverse order, one per cycle. The error flag rises one cycle after the last undo, when all core resets read 1 and both clock enables read 0.
- R7: The application reset output is a single-cycle pulse, given exactly once per successful sequence, between the core and sticky releases. A stop never produces it.
- R8: A stop clears the training enable, then one cycle later asserts all seven core resets at once, then one cycle later clears both clock enables, then one cycle later drives the peripheral reset pin low.
- R9: After the peripheral reset is asserted by a stop, a start is ignored for HOLD_US microseconds and accepted afterwards.
- R10: Done rises between (SETTLE_US-1)*CLK_MHZ and SETTLE_US*CLK_MHZ+2 cycles after the peripheral reset pin goes high.
- R11: A start outside IDLE has no effect. The error code stays set until the next accepted start, which clears it.
- R12: The training enable rises exactly one cycle after done and is 1 only while every reset is released and both clocks are enabled. A stop clears done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin the release sequence |
| stop_i | input | 1 | Single-cycle request to shut the controller down |
| phy_rst_req_i | input | 1 | Power-management request holding the PHY in reset |
| core_rst_req_i | input | 1 | Power-management request holding the core in reset |
| core_rst_o | output | 7 | Core resets, 1 = asserted; bit 0 power, 1 hot, 2 PHY, 3 pipe, 4 core, 5 sticky, 6 non-sticky |
| app_rst_o | output | 1 | One-cycle application-domain reset pulse |
| app_clk_en_o | output | 1 | Application clock enable |
| ref_clk_en_o | output | 1 | Reference clock enable |
| train_en_o | output | 1 | Link-training enable |
| periph_rst_n_o | output | 1 | Peripheral reset, low = asserted |
| done_o | output | 1 | Sequence complete |
| err_o | output | 1 | A wait timed out |
| err_code_o | output | 2 | 0 none, 1 PHY wait timeout, 2 core wait timeout |

## Verification
The assertions assume that start and stop are single-cycle pulses and that stop is never raised in the cycle that ends a stop sequence. The training check after a stop relies on that. The bench drives every pulse for exactly one cycle on the falling edge. It lowers each reset request only while the matching wait is pending or before the start, and it keeps them steady otherwise. The sweep moves the two request release times against each other over several microsecond offsets. It also holds each request high until its wait times out, so every unwind path is exercised.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int NUM_CORE_RST = 7;

    // core reset bit positions (release order)
    localparam int RI_PWR     = 0;
    localparam int RI_HOT     = 1;
    localparam int RI_PHY     = 2;
    localparam int RI_PIPE    = 3;
    localparam int RI_CORE    = 4;
    localparam int RI_STICKY  = 5;
    localparam int RI_NSTICKY = 6;

    localparam int CI_APP = 0;
    localparam int CI_REF = 1;

    // undo stages, numbered in the order the actions were taken
    localparam logic [2:0] UW_PWR    = 3'd1;
    localparam logic [2:0] UW_HOT    = 3'd2;
    localparam logic [2:0] UW_PHY    = 3'd3;
    localparam logic [2:0] UW_APPCLK = 3'd4;
    localparam logic [2:0] UW_REFCLK = 3'd5;

    typedef enum logic [4:0] {
        S_IDLE, S_REL_PWR, S_REL_HOT, S_WAIT_PHY, S_REL_PHY,
        S_EN_APPCLK, S_EN_REFCLK, S_WAIT_CORE, S_REL_PIPE, S_REL_CORE,
        S_PULSE_APP, S_REL_STICKY, S_REL_NSTICKY, S_REL_PERIPH, S_SETTLE,
        S_DONE, S_UNWIND, S_FAILED, S_STOP_TRAIN, S_STOP_CORE,
        S_STOP_CLK, S_STOP_PERIPH, S_HOLD
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_PHY_WAIT  = 2'd1,
        ERR_CORE_WAIT = 2'd2
    } err_code_t;

endpackage

// File: rtl/rstseq_tick.sv
module rstseq_tick #(
    parameter int TICK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(TICK_DIV);
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (clr_i)                       cnt_q <= '0;
        else if (tick_i && cnt_q != limit_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = !clr_i && (cnt_q == limit_i);
endmodule

// File: rtl/ctrl_reset_sequencer.sv
module ctrl_reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int POLL_US   = 1000,
    parameter int SETTLE_US = 100,
    parameter int HOLD_US   = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       phy_rst_req_i,
    input  logic       core_rst_req_i,
    output logic [6:0] core_rst_o,
    output logic       app_rst_o,
    output logic       app_clk_en_o,
    output logic       ref_clk_en_o,
    output logic       train_en_o,
    output logic       periph_rst_n_o,
    output logic       done_o,
    output logic       err_o,
    output logic [1:0] err_code_o
);
    localparam int TMAX_PS = (POLL_US > SETTLE_US) ? POLL_US : SETTLE_US;
    localparam int TMAX    = (TMAX_PS > HOLD_US) ? TMAX_PS : HOLD_US;
    localparam int TW      = $clog2(TMAX + 1);

    seq_state_t state_q, nxt;
    logic [2:0] stage_q;
    err_code_t  fc_q, err_q;

    logic [NUM_CORE_RST-1:0] rel_q;
    logic [1:0]              clk_q;
    logic                    periph_q, app_q, train_q;

    logic          tick, tmr_exp, tmr_clr, stop_ok;
    logic [TW-1:0] tmr_lim;

    rstseq_tick #(.TICK_DIV(CLK_MHZ)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    always_comb begin
        tmr_clr = !(state_q inside {S_WAIT_PHY, S_WAIT_CORE, S_SETTLE, S_HOLD});
        if (state_q inside {S_WAIT_PHY, S_WAIT_CORE}) tmr_lim = TW'(POLL_US);
        else if (state_q == S_SETTLE)                 tmr_lim = TW'(SETTLE_US);
        else                                          tmr_lim = TW'(HOLD_US);
    end

    rstseq_timer #(.CW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .tick_i    (tick),
        .limit_i   (tmr_lim),
        .expired_o (tmr_exp)
    );

    assign stop_ok = stop_i &&
        !(state_q inside {S_STOP_TRAIN, S_STOP_CORE, S_STOP_CLK, S_STOP_PERIPH, S_HOLD});

    // next-state logic
    always_comb begin
        nxt = state_q;
        if (stop_ok) begin
            nxt = S_STOP_TRAIN;
        end else begin
            unique case (state_q)
                S_IDLE:        if (start_i) nxt = S_REL_PWR;
                S_REL_PWR:     nxt = S_REL_HOT;
                S_REL_HOT:     nxt = S_WAIT_PHY;
                S_WAIT_PHY: begin
                    if (tick && !phy_rst_req_i) nxt = S_REL_PHY;
                    else if (tmr_exp)           nxt = S_UNWIND;
                end
                S_REL_PHY:     nxt = S_EN_APPCLK;
                S_EN_APPCLK:   nxt = S_EN_REFCLK;
                S_EN_REFCLK:   nxt = S_WAIT_CORE;
                S_WAIT_CORE: begin
                    if (tick && !core_rst_req_i) nxt = S_REL_PIPE;
                    else if (tmr_exp)            nxt = S_UNWIND;
                end
                S_REL_PIPE:    nxt = S_REL_CORE;
                S_REL_CORE:    nxt = S_PULSE_APP;
                S_PULSE_APP:   nxt = S_REL_STICKY;
                S_REL_STICKY:  nxt = S_REL_NSTICKY;
                S_REL_NSTICKY: nxt = S_REL_PERIPH;
                S_REL_PERIPH:  nxt = S_SETTLE;
                S_SETTLE:      if (tmr_exp) nxt = S_DONE;
                S_DONE:        nxt = S_DONE;
                S_UNWIND:      if (stage_q == UW_PWR) nxt = S_FAILED;
                S_FAILED:      nxt = S_IDLE;
                S_STOP_TRAIN:  nxt = S_STOP_CORE;
                S_STOP_CORE:   nxt = S_STOP_CLK;
                S_STOP_CLK:    nxt = S_STOP_PERIPH;
                S_STOP_PERIPH: nxt = S_HOLD;
                S_HOLD:        if (tmr_exp) nxt = S_IDLE;
                default:       nxt = S_IDLE;
            endcase
        end
    end

    // state register with its unwind stage and error bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            stage_q <= '0;
            fc_q    <= ERR_NONE;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= nxt;
            if (state_q == S_WAIT_PHY && nxt == S_UNWIND) begin
                stage_q <= UW_HOT;
                fc_q    <= ERR_PHY_WAIT;
            end else if (state_q == S_WAIT_CORE && nxt == S_UNWIND) begin
                stage_q <= UW_REFCLK;
                fc_q    <= ERR_CORE_WAIT;
            end else if (state_q == S_UNWIND) begin
                stage_q <= stage_q - 3'd1;
            end
            if (state_q == S_IDLE && nxt == S_REL_PWR) err_q <= ERR_NONE;
            else if (state_q == S_FAILED)              err_q <= fc_q;
        end
    end

    // registered outputs, one action per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_q    <= '0;
            clk_q    <= '0;
            periph_q <= 1'b0;
            app_q    <= 1'b0;
            train_q  <= 1'b0;
        end else begin
            app_q <= (state_q == S_PULSE_APP);
            case (state_q)
                S_REL_PWR:     rel_q[RI_PWR]     <= 1'b1;
                S_REL_HOT:     rel_q[RI_HOT]     <= 1'b1;
                S_REL_PHY:     rel_q[RI_PHY]     <= 1'b1;
                S_EN_APPCLK:   clk_q[CI_APP]     <= 1'b1;
                S_EN_REFCLK:   clk_q[CI_REF]     <= 1'b1;
                S_REL_PIPE:    rel_q[RI_PIPE]    <= 1'b1;
                S_REL_CORE:    rel_q[RI_CORE]    <= 1'b1;
                S_REL_STICKY:  rel_q[RI_STICKY]  <= 1'b1;
                S_REL_NSTICKY: rel_q[RI_NSTICKY] <= 1'b1;
                S_REL_PERIPH:  periph_q          <= 1'b1;
                S_DONE:        train_q           <= 1'b1;
                S_UNWIND: begin
                    case (stage_q)
                        UW_PWR:    rel_q[RI_PWR] <= 1'b0;
                        UW_HOT:    rel_q[RI_HOT] <= 1'b0;
                        UW_PHY:    rel_q[RI_PHY] <= 1'b0;
                        UW_APPCLK: clk_q[CI_APP] <= 1'b0;
                        UW_REFCLK: clk_q[CI_REF] <= 1'b0;
                        default:   ;
                    endcase
                end
                S_STOP_TRAIN:  train_q  <= 1'b0;
                S_STOP_CORE:   rel_q    <= '0;
                S_STOP_CLK:    clk_q    <= '0;
                S_STOP_PERIPH: periph_q <= 1'b0;
                default:       ;
            endcase
        end
    end

    assign core_rst_o     = ~rel_q;
    assign app_rst_o      = app_q;
    assign app_clk_en_o   = clk_q[CI_APP];
    assign ref_clk_en_o   = clk_q[CI_REF];
    assign train_en_o     = train_q;
    assign periph_rst_n_o = periph_q;
    assign done_o         = (state_q == S_DONE);
    assign err_code_o     = err_q;
    assign err_o          = (err_q != ERR_NONE);
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_i,
    input logic [6:0] core_rst_o,
    input logic       app_rst_o,
    input logic       app_clk_en_o,
    input logic       ref_clk_en_o,
    input logic       train_en_o,
    input logic       periph_rst_n_o,
    input logic       done_o,
    input logic       err_o,
    input logic [1:0] err_code_o
);
    p_phy_after_hot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o[2]) |-> !core_rst_o[1] && !core_rst_o[0]);

    p_pipe_needs_clocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o[3]) |-> app_clk_en_o && ref_clk_en_o);

    p_periph_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_rst_n_o) |-> core_rst_o == 7'h00);

    p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_code_o != 2'd3);

    p_fail_unwound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> core_rst_o == 7'h7f && !app_clk_en_o && !ref_clk_en_o);

    p_app_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        app_rst_o |=> !app_rst_o);

    p_stop_train_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && train_en_o |=> ##1 !train_en_o);

    p_done_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> periph_rst_n_o && core_rst_o == 7'h00);

    p_train_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        train_en_o |-> core_rst_o == 7'h00 && periph_rst_n_o && app_clk_en_o && ref_clk_en_o);
endmodule

bind ctrl_reset_sequencer rstseq_checker u_rstseq_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .stop_i         (stop_i),
    .core_rst_o     (core_rst_o),
    .app_rst_o      (app_rst_o),
    .app_clk_en_o   (app_clk_en_o),
    .ref_clk_en_o   (ref_clk_en_o),
    .train_en_o     (train_en_o),
    .periph_rst_n_o (periph_rst_n_o),
    .done_o         (done_o),
    .err_o          (err_o),
    .err_code_o     (err_code_o)
);

// File: tb/ctrl_reset_sequencer_bench.sv
`timescale 1ns/1ps
module ctrl_reset_sequencer_bench;
    localparam int MHZ    = 2;
    localparam int POLL   = 8;
    localparam int SETTLE = 4;
    localparam int HOLD   = 20;
    localparam int WD_CYC = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0;
    logic phy_req = 1'b1, core_req = 1'b1;
    logic [6:0] core_rst_o;
    logic app_rst_o, app_clk_en_o, ref_clk_en_o, train_en_o;
    logic periph_rst_n_o, done_o, err_o;
    logic [1:0] err_code_o;

    int n_chk = 0, n_err = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ctrl_reset_sequencer #(
        .CLK_MHZ(MHZ), .POLL_US(POLL), .SETTLE_US(SETTLE), .HOLD_US(HOLD)
    ) u_ctrl_reset_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .phy_rst_req_i(phy_req), .core_rst_req_i(core_req),
        .core_rst_o(core_rst_o), .app_rst_o(app_rst_o),
        .app_clk_en_o(app_clk_en_o), .ref_clk_en_o(ref_clk_en_o),
        .train_en_o(train_en_o), .periph_rst_n_o(periph_rst_n_o),
        .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    // edge time stamps, taken on the falling clock
    int t_rel [7] = '{default: -1};
    int t_asrt[7] = '{default: -1};
    int t_clkon [2] = '{default: -1};
    int t_clkoff[2] = '{default: -1};
    int t_pon = -1, t_poff = -1, t_app = -1, n_app = 0;
    int t_done = -1, t_err = -1, t_tron = -1, t_troff = -1;
    logic [6:0] p_core = 7'h7f;
    logic [1:0] p_clk = 2'b00;
    logic p_per = 1'b0, p_app = 1'b0, p_done = 1'b0, p_err = 1'b0, p_tr = 1'b0;

    always @(negedge clk) if (rst_n) begin
        for (int i = 0; i < 7; i++) begin
            if (p_core[i] && !core_rst_o[i]) t_rel[i] = cyc;
            if (!p_core[i] && core_rst_o[i]) t_asrt[i] = cyc;
        end
        if (!p_clk[0] && app_clk_en_o) t_clkon[0] = cyc;
        if (p_clk[0] && !app_clk_en_o) t_clkoff[0] = cyc;
        if (!p_clk[1] && ref_clk_en_o) t_clkon[1] = cyc;
        if (p_clk[1] && !ref_clk_en_o) t_clkoff[1] = cyc;
        if (!p_per && periph_rst_n_o) t_pon = cyc;
        if (p_per && !periph_rst_n_o) t_poff = cyc;
        if (!p_app && app_rst_o) begin t_app = cyc; n_app++; end
        if (!p_done && done_o) t_done = cyc;
        if (!p_err && err_o) t_err = cyc;
        if (!p_tr && train_en_o) t_tron = cyc;
        if (p_tr && !train_en_o) t_troff = cyc;
        p_core = core_rst_o; p_clk = {ref_clk_en_o, app_clk_en_o};
        p_per = periph_rst_n_o; p_app = app_rst_o; p_done = done_o;
        p_err = err_o; p_tr = train_en_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic run_seq(input int phy_d, input int core_d, input bit extra);
        int base, napp0, t_pd, t_cd;
        int s[11];
        base = cyc; napp0 = n_app; t_pd = -1; t_cd = -1;
        phy_req = (phy_d > 0); core_req = (core_d > 0);
        pulse_start();
        if (extra) begin wait_cycles(1); pulse_start(); end
        if (phy_d > 0) begin
            wait_cycles(phy_d * MHZ);
            chk(core_rst_o[2] == 1'b1, "R3 PHY reset held while requested", core_rst_o[2], 1);
            phy_req = 1'b0; t_pd = cyc;
        end
        for (int n = 0; n < 200 && !ref_clk_en_o; n++) @(negedge clk);
        if (core_d > 0) begin
            wait_cycles(core_d * MHZ);
            chk(core_rst_o[3] == 1'b1, "R4 pipe reset held while requested", core_rst_o[3], 1);
            core_req = 1'b0; t_cd = cyc;
        end
        for (int n = 0; n < 500 && !done_o; n++) @(negedge clk);
        if (extra) pulse_start();
        wait_cycles(3);
        s = '{t_rel[0], t_rel[1], t_rel[2], t_clkon[0], t_clkon[1], t_rel[3],
              t_rel[4], t_app, t_rel[5], t_rel[6], t_pon};
        chk(s[0] > base, "R2 first release after start", s[0], base + 1);
        for (int i = 1; i < 11; i++)
            chk(s[i] > s[i-1], "R2 release order", s[i], s[i-1] + 1);
        if (phy_d > 0)
            chk(t_rel[2] > t_pd && t_rel[2] - t_pd <= MHZ + 3, "R3 PHY release delay", t_rel[2] - t_pd, MHZ);
        if (core_d > 0)
            chk(t_rel[3] > t_cd && t_rel[3] - t_cd <= MHZ + 3, "R4 pipe release delay", t_rel[3] - t_cd, MHZ);
        chk(n_app - napp0 == 1, "R7 single application pulse", n_app - napp0, 1);
        chk(t_done - t_pon >= (SETTLE - 1) * MHZ && t_done - t_pon <= SETTLE * MHZ + 2,
            "R10 settle time", t_done - t_pon, SETTLE * MHZ);
        chk(t_tron - t_done == 1, "R12 training after done", t_tron - t_done, 1);
        chk(done_o && core_rst_o == 7'h00 && err_o == 1'b0, "R11 sequence done, no error",
            {done_o, core_rst_o}, 8'h80);
    endtask

    task automatic stop_and_hold();
        int base, napp0, tgt;
        base = cyc; napp0 = n_app;
        pulse_stop();
        wait_cycles(8);
        chk(t_troff > base, "R8 training cleared", t_troff, base + 1);
        chk(t_asrt[0] - t_troff == 1, "R8 core resets after training", t_asrt[0] - t_troff, 1);
        for (int i = 1; i < 7; i++)
            chk(t_asrt[i] == t_asrt[0], "R8 core resets together", t_asrt[i], t_asrt[0]);
        chk(t_clkoff[0] - t_asrt[0] == 1 && t_clkoff[1] == t_clkoff[0], "R8 clocks gated",
            t_clkoff[0] - t_asrt[0], 1);
        chk(t_poff - t_clkoff[0] == 1, "R8 peripheral reset last", t_poff - t_clkoff[0], 1);
        chk(n_app == napp0, "R7 stop gives no pulse", n_app - napp0, 0);
        chk(done_o == 1'b0, "R12 done cleared by stop", done_o, 0);
        tgt = t_poff + HOLD * MHZ - MHZ - 2;
        while (cyc < tgt) @(negedge clk);
        pulse_start();
        wait_cycles(4);
        chk(core_rst_o == 7'h7f, "R9 start ignored during hold", core_rst_o, 7'h7f);
        tgt = t_poff + HOLD * MHZ + MHZ + 6;
        while (cyc < tgt) @(negedge clk);
    endtask

    initial begin
        wait_cycles(WD_CYC);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYC, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int base;
        wait_cycles(4);
        chk(core_rst_o == 7'h7f && !app_clk_en_o && !ref_clk_en_o && !periph_rst_n_o,
            "R1 resets held in reset", core_rst_o, 7'h7f);
        rst_n = 1'b1;
        wait_cycles(6);
        chk(!done_o && !err_o && !train_en_o && !app_rst_o && core_rst_o == 7'h7f,
            "R1 idle after reset", {done_o, err_o, train_en_o, app_rst_o}, 0);

        // sweep of request release offsets
        for (int d = 0; d < 4; d++) begin
            run_seq(d, 3 - d, d == 1);
            stop_and_hold();
        end

        // PHY wait timeout
        base = cyc; phy_req = 1'b1; core_req = 1'b1;
        pulse_start();
        for (int n = 0; n < POLL * MHZ * 3 && !err_o; n++) @(negedge clk);
        wait_cycles(2);
        chk(err_code_o == 2'd1, "R5 PHY timeout code", err_code_o, 1);
        chk(t_err - t_rel[1] >= (POLL - 1) * MHZ && t_err - t_rel[1] <= POLL * MHZ + 10,
            "R5 PHY timeout length", t_err - t_rel[1], POLL * MHZ);
        chk(t_asrt[1] > base && t_asrt[0] - t_asrt[1] == 1, "R6 hot then power re-asserted",
            t_asrt[0] - t_asrt[1], 1);
        chk(!(t_clkon[0] > base), "R6 clocks never enabled", t_clkon[0], -1);
        chk(t_err - t_asrt[0] == 1 && core_rst_o == 7'h7f, "R6 error after unwind",
            t_err - t_asrt[0], 1);
        wait_cycles(30);
        chk(err_o && err_code_o == 2'd1, "R11 error held", err_code_o, 1);

        // core wait timeout
        base = cyc; phy_req = 1'b0; core_req = 1'b1;
        pulse_start();
        wait_cycles(2);
        chk(!err_o, "R11 error cleared by start", err_o, 0);
        for (int n = 0; n < POLL * MHZ * 3 + 40 && !err_o; n++) @(negedge clk);
        wait_cycles(2);
        chk(err_code_o == 2'd2, "R5 core timeout code", err_code_o, 2);
        chk(t_err - t_clkon[1] >= (POLL - 1) * MHZ && t_err - t_clkon[1] <= POLL * MHZ + 12,
            "R5 core timeout length", t_err - t_clkon[1], POLL * MHZ);
        chk(t_clkoff[1] > base && t_clkoff[0] - t_clkoff[1] == 1, "R6 ref then app clock off",
            t_clkoff[0] - t_clkoff[1], 1);
        chk(t_asrt[2] - t_clkoff[0] == 1, "R6 PHY reset after clocks", t_asrt[2] - t_clkoff[0], 1);
        chk(t_asrt[1] - t_asrt[2] == 1 && t_asrt[0] - t_asrt[1] == 1, "R6 hot then power",
            t_asrt[0] - t_asrt[2], 2);
        chk(!(t_rel[3] > base), "R4 pipe never released", t_rel[3], -1);
        chk(core_rst_o == 7'h7f && !app_clk_en_o && !ref_clk_en_o, "R6 fully unwound",
            core_rst_o, 7'h7f);

        // recovery after a failure
        run_seq(1, 1, 1'b0);
        stop_and_hold();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule